// File: doc/BRIEF.md
# Host Bridge Configuration Space

This block is the 256-byte configuration space of a host bridge's function 0. A bus-side agent presents a byte address, a function number, write data and a write strobe; the block applies a per-byte write policy and returns the stored byte combinationally on the read port. Identification bytes are hard read-only. The command byte has one writable bit. The status byte's error flags are cleared by writing one to them. Every other byte stores whatever is written to it.

Three of the stored bytes control how the 0xC0000-0xFFFFF window is shadowed. The block decodes them into ten 2-bit attribute fields: eight 16 KB segments from 0xC0000 to 0xDC000, one 64 KB region at 0xE0000 and one 64 KB region at 0xF0000. It also drives a flag that shows when the top BIOS region is shadowed, and a per-region change pulse so that downstream routing logic can remap the affected range. A synchronous active-high reset loads the identification values and the DRAM timing values. Every other byte resets to zero.

Top module: `hbcfg_space`

## Requirements
- R1: After reset, bytes 0x00..0x03 read 0x06, 0x11, 0x85, 0x05, byte 0x04 reads 0x07, bytes 0x06 and 0x07 read 0xA0 and 0x02, byte 0x0B reads 0x06, and the remaining header bytes 0x05, 0x08..0x0A and 0x0C..0x0F read 0x00.
- R2: A function-0 write to byte 0x00..0x03, 0x08..0x0B, 0x0E or 0x0F leaves the stored byte unchanged.
- R3: A function-0 write to byte 0x04 replaces only bit 6 with the written bit 6; bits 7 and 5..0 keep their values.
- R4: A function-0 write to byte 0x07 clears each of bits 7, 5 and 4 that is written as 1; zeros written there, and all other bits of the byte, cause no change.
- R5: After reset, byte 0x58 reads 0x40, 0x59 reads 0x05, each of 0x5A..0x5F reads 0x01, 0x64 reads 0xAB, and every byte at 0x10 or above not named here reads 0x00.
- R6: A function-0 write to any byte not governed by R2, R3 or R4 (including 0x05, 0x06, 0x0C, 0x0D and 0x10..0xFF) stores the written byte, and a function-0 read of it returns that byte from the first cycle after the write edge.
- R7: `seg_attr` bits [2i+1:2i] carry region i. Regions 0..3 are bits 1:0, 3:2, 5:4 and 7:6 of byte 0x61 (segments 0xC0000, 0xC4000, 0xC8000, 0xCC000). Regions 4..7 are the same fields of byte 0x62 (0xD0000..0xDC000). Region 8 (0xE0000) is bits 7:6 of byte 0x63, and region 9 (0xF0000) is bits 5:4 of byte 0x63.
- R8: `bios_shadow` equals bit 5 of byte 0x63. It is reloaded only by a write that changes bits 5:4 of that byte.
- R9: `region_chg[i]` is high for exactly the one cycle after a write edge that alters region i's attribute field. It stays low after a write that leaves the field as it was.
- R10: With a nonzero function number, a read returns 0xFF and a write changes no stored byte, no attribute and no change pulse.
- R11: Asserting reset in the middle of operation restores all defaults at the next clock edge, clears `bios_shadow` and `seg_attr`, and holds `region_chg` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe, sampled at the rising edge |
| cfg_func | input | FUNC_W | Function number; only 0 is implemented |
| cfg_addr | input | 8 | Byte address for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, combinational from address and function |
| seg_attr | output | 20 | Ten 2-bit shadow attributes, region i at bits [2i+1:2i] |
| bios_shadow | output | 1 | Top BIOS region shadowed flag |
| region_chg | output | 10 | One-cycle pulse per region whose attribute changed |

## Verification
The read port has no register on its path, so a read is checked a short delay after the address settles, in the same cycle. A stored byte becomes visible at the first sample after the write's rising edge. The attribute outputs, the BIOS flag and the change pulses change at that same edge, so they are checked at that sample, and each pulse is checked again one cycle later to confirm it has returned to zero. The bench drives every input on the falling edge and samples on the next falling edge, which keeps each check exactly one register stage behind its stimulus.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int CFG_ADDR_W = 8;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 1 << CFG_ADDR_W;

  // shadow control: three consecutive bytes, ten 2-bit regions
  localparam int NUM_SHD    = 3;
  localparam int ATTR_W     = 2;
  localparam int NUM_REGION = 10;
  localparam int ATTR_VEC_W = NUM_REGION * ATTR_W;
  localparam int REG_TOP    = 9;   // region holding 0xF0000

  typedef logic [BYTE_W-1:0]     byte_t;
  typedef logic [CFG_ADDR_W-1:0] addr_t;
  typedef logic [ATTR_VEC_W-1:0] attr_vec_t;
  typedef logic [NUM_SHD-1:0][BYTE_W-1:0] shd_bytes_t;

  typedef enum logic [1:0] {
    ACC_RW,
    ACC_RO,
    ACC_MASKED,
    ACC_W1C
  } acc_e;

  localparam byte_t CMD_WMASK = 8'h40;
  localparam byte_t STS_W1C   = 8'hB0;

  function automatic acc_e access_of(input addr_t a);
    case (a)
      8'h00, 8'h01, 8'h02, 8'h03,
      8'h08, 8'h09, 8'h0A, 8'h0B,
      8'h0E, 8'h0F: return ACC_RO;
      8'h04:        return ACC_MASKED;
      8'h07:        return ACC_W1C;
      default:      return ACC_RW;
    endcase
  endfunction

  function automatic byte_t default_of(input addr_t a);
    case (a)
      8'h00: return 8'h06;
      8'h01: return 8'h11;
      8'h02: return 8'h85;
      8'h03: return 8'h05;
      8'h04: return 8'h07;
      8'h06: return 8'hA0;
      8'h07: return 8'h02;
      8'h0B: return 8'h06;
      8'h58: return 8'h40;
      8'h59: return 8'h05;
      8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F: return 8'h01;
      8'h64: return 8'hAB;
      default: return 8'h00;
    endcase
  endfunction

  // lay the three control bytes out as the region attribute vector
  function automatic attr_vec_t map_attr(input shd_bytes_t b);
    attr_vec_t v;
    v[7:0]   = b[0];
    v[15:8]  = b[1];
    v[17:16] = b[2][7:6];
    v[19:18] = b[2][5:4];
    return v;
  endfunction

endpackage

// File: rtl/hbcfg_policy.sv
module hbcfg_policy
  import hbcfg_pkg::*;
(
  input  addr_t addr,
  input  byte_t cur,
  input  byte_t wdata,
  output logic  writable,
  output byte_t nxt
);

  acc_e acc;

  always_comb begin
    acc      = access_of(addr);
    writable = (acc != ACC_RO);
    unique case (acc)
      ACC_RO:     nxt = cur;
      ACC_MASKED: nxt = (cur & ~CMD_WMASK) | (wdata & CMD_WMASK);
      ACC_W1C:    nxt = cur & ~(wdata & STS_W1C);
      default:    nxt = wdata;
    endcase
  end

endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
  import hbcfg_pkg::*;
#(
  parameter addr_t SHD_BASE = 8'h61
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  addr_t      addr,
  input  byte_t      wbyte,
  output byte_t      rbyte,
  output shd_bytes_t shd_bytes
);

  logic [NUM_BYTES-1:0][BYTE_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        mem[i] <= default_of(CFG_ADDR_W'(i));
      end
    end else if (we) begin
      mem[addr] <= wbyte;
    end
  end

  assign rbyte = mem[addr];

  for (genvar k = 0; k < NUM_SHD; k++) begin : g_shd_tap
    assign shd_bytes[k] = mem[SHD_BASE + CFG_ADDR_W'(k)];
  end

endmodule

// File: rtl/hbcfg_shadow.sv
module hbcfg_shadow
  import hbcfg_pkg::*;
#(
  parameter addr_t SHD_BASE = 8'h61
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  addr_t                 addr,
  input  byte_t                 wbyte,
  input  shd_bytes_t            shd_bytes,
  output attr_vec_t             seg_attr,
  output logic                  bios_shadow,
  output logic [NUM_REGION-1:0] region_chg
);

  shd_bytes_t            cand;
  attr_vec_t             cur_attr;
  attr_vec_t             new_attr;
  logic [NUM_REGION-1:0] diff;

  // control bytes as they will be after this edge's write
  for (genvar k = 0; k < NUM_SHD; k++) begin : g_cand
    assign cand[k] = (we && addr == SHD_BASE + CFG_ADDR_W'(k)) ? wbyte : shd_bytes[k];
  end

  assign cur_attr = map_attr(shd_bytes);
  assign new_attr = map_attr(cand);

  for (genvar r = 0; r < NUM_REGION; r++) begin : g_diff
    assign diff[r] = |(new_attr[r*ATTR_W +: ATTR_W] ^ cur_attr[r*ATTR_W +: ATTR_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_chg  <= '0;
      bios_shadow <= 1'b0;
    end else begin
      region_chg <= diff;
      if (diff[REG_TOP]) begin
        bios_shadow <= new_attr[REG_TOP*ATTR_W + 1];
      end
    end
  end

  assign seg_attr = cur_attr;

endmodule

// File: rtl/hbcfg_space.sv
module hbcfg_space
  import hbcfg_pkg::*;
#(
  parameter int    FUNC_W   = 3,
  parameter addr_t SHD_BASE = 8'h61
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [FUNC_W-1:0]     cfg_func,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  output logic [ATTR_VEC_W-1:0] seg_attr,
  output logic                  bios_shadow,
  output logic [NUM_REGION-1:0] region_chg
);

  logic       func0;
  logic       writable;
  logic       store_we;
  byte_t      stored;
  byte_t      nxt;
  shd_bytes_t shd_bytes;

  assign func0    = (cfg_func == '0);
  assign store_we = cfg_we && func0 && writable;

  hbcfg_policy u_policy (
    .addr     (cfg_addr),
    .cur      (stored),
    .wdata    (cfg_wdata),
    .writable (writable),
    .nxt      (nxt)
  );

  hbcfg_regfile #(.SHD_BASE(SHD_BASE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (store_we),
    .addr      (cfg_addr),
    .wbyte     (nxt),
    .rbyte     (stored),
    .shd_bytes (shd_bytes)
  );

  hbcfg_shadow #(.SHD_BASE(SHD_BASE)) u_shadow (
    .clk         (clk),
    .rst         (rst),
    .we          (store_we),
    .addr        (cfg_addr),
    .wbyte       (nxt),
    .shd_bytes   (shd_bytes),
    .seg_attr    (seg_attr),
    .bios_shadow (bios_shadow),
    .region_chg  (region_chg)
  );

  assign cfg_rdata = func0 ? stored : 8'hFF;

endmodule

// File: rtl/hbcfg_space_chk.sv
module hbcfg_space_chk
  import hbcfg_pkg::*;
#(
  parameter int FUNC_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_we,
  input logic [FUNC_W-1:0]     cfg_func,
  input logic [7:0]            cfg_addr,
  input logic [7:0]            cfg_wdata,
  input logic [7:0]            cfg_rdata,
  input logic [ATTR_VEC_W-1:0] seg_attr,
  input logic                  bios_shadow,
  input logic [NUM_REGION-1:0] region_chg
);

  logic armed;
  logic f0;
  logic ro_addr;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign f0      = (cfg_func == '0);
  assign ro_addr = (access_of(cfg_addr) == ACC_RO);

  // R2: read-only byte unchanged by a write
  p_ro_hold_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(cfg_we && f0 && ro_addr) && f0 && cfg_addr == $past(cfg_addr)
    |-> cfg_rdata == $past(cfg_rdata));

  // R3: command byte, only bit 6 follows the write
  p_cmd_bit_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(cfg_we && f0 && cfg_addr == 8'h04) && f0 && cfg_addr == 8'h04
    |-> cfg_rdata == (($past(cfg_rdata) & 8'hBF) | ($past(cfg_wdata) & 8'h40)));

  // R4: status byte write-one-to-clear
  p_sts_w1c_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(cfg_we && f0 && cfg_addr == 8'h07) && f0 && cfg_addr == 8'h07
    |-> cfg_rdata == ($past(cfg_rdata) & ~($past(cfg_wdata) & 8'hB0)));

  // R8: BIOS flag tracks the upper bit of the top region field
  p_bios_bit_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    bios_shadow == seg_attr[REG_TOP*ATTR_W + 1]);

  // R9: a pulse only follows a write
  p_chg_after_wr_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    region_chg != '0 |-> $past(cfg_we));

  for (genvar r = 0; r < NUM_REGION; r++) begin : g_chg
    // R9: a pulse marks a real change of that field
    p_chg_real_r9: assert property (@(posedge clk) disable iff (rst || !armed)
      region_chg[r] |-> seg_attr[r*ATTR_W +: ATTR_W] != $past(seg_attr[r*ATTR_W +: ATTR_W]));
  end

  // R10: other function numbers leave the shadow state alone
  p_func_ign_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(cfg_we && !f0) |-> seg_attr == $past(seg_attr) && region_chg == '0);

  // R11: outputs cleared after a reset edge
  p_rst_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> region_chg == '0 && seg_attr == '0 && !bios_shadow);

endmodule

bind hbcfg_space hbcfg_space_chk #(.FUNC_W(FUNC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_func    (cfg_func),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .seg_attr    (seg_attr),
  .bios_shadow (bios_shadow),
  .region_chg  (region_chg)
);

// File: tb/test_hbcfg_space.sv
`timescale 1ns/1ps
module test_hbcfg_space;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [19:0] seg_attr;
  logic        bios_shadow;
  logic [9:0]  region_chg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hbcfg_space i_hbcfg_space (
    .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_func (cfg_func),
    .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
    .seg_attr (seg_attr), .bios_shadow (bios_shadow), .region_chg (region_chg)
  );

  // vector: [30:27] req, [26:24] func, [23:16] addr, [15:8] wdata, [7:0] expected read
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {4'd2,  3'd0, 8'h00, 8'hFF, 8'h06},  // R2
    {4'd2,  3'd0, 8'h02, 8'h00, 8'h85},  // R2
    {4'd2,  3'd0, 8'h0B, 8'h55, 8'h06},  // R2
    {4'd2,  3'd0, 8'h0E, 8'h12, 8'h00},  // R2
    {4'd3,  3'd0, 8'h04, 8'hFF, 8'h47},  // R3
    {4'd3,  3'd0, 8'h04, 8'hB8, 8'h07},  // R3
    {4'd4,  3'd0, 8'h07, 8'h00, 8'h02},  // R4
    {4'd4,  3'd0, 8'h07, 8'hFF, 8'h02},  // R4
    {4'd6,  3'd0, 8'h06, 8'h3C, 8'h3C},  // R6
    {4'd6,  3'd0, 8'h05, 8'h5A, 8'h5A},  // R6
    {4'd6,  3'd0, 8'h80, 8'hC3, 8'hC3},  // R6
    {4'd6,  3'd0, 8'hFF, 8'h01, 8'h01},  // R6
    {4'd6,  3'd0, 8'h58, 8'h12, 8'h12},  // R6
    {4'd10, 3'd1, 8'h80, 8'h00, 8'hC3},  // R10
    {4'd10, 3'd7, 8'h06, 8'h00, 8'h3C},  // R10
    {4'd6,  3'd0, 8'h0C, 8'h77, 8'h77}   // R6
  };

  function automatic logic [7:0] exp_default(input logic [7:0] a);
    case (a)
      8'h00: return 8'h06;  8'h01: return 8'h11;
      8'h02: return 8'h85;  8'h03: return 8'h05;
      8'h04: return 8'h07;  8'h06: return 8'hA0;
      8'h07: return 8'h02;  8'h0B: return 8'h06;
      8'h58: return 8'h40;  8'h59: return 8'h05;
      8'h64: return 8'hAB;
      default: return (a >= 8'h5A && a <= 8'h5F) ? 8'h01 : 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] fn, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_func = fn; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_func = '0;
  endtask

  task automatic read(input logic [7:0] a, output logic [7:0] d);
    cfg_func = '0; cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 and R5: every reset value
    for (int a = 0; a < 256; a++) begin
      read(8'(a), rd);
      check((a < 16) ? "R1 header default" : "R5 default", {24'd0, rd}, {24'd0, exp_default(8'(a))});
    end
    check("R11 attr at reset", {12'd0, seg_attr}, 32'd0);
    check("R11 pulse at reset", {22'd0, region_chg}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      write(VEC[v][26:24], VEC[v][23:16], VEC[v][15:8]);
      read(VEC[v][23:16], rd);
      check($sformatf("R%0d vector %0d", VEC[v][30:27], v), {24'd0, rd}, {24'd0, VEC[v][7:0]});
    end

    // R10: foreign function read
    cfg_func = 3'd3; cfg_addr = 8'h80; #1;
    check("R10 foreign read", {24'd0, cfg_rdata}, 32'hFF);
    cfg_func = '0;

    // R7 / R9: shadow byte 0x61
    write(3'd0, 8'h61, 8'hE4);
    check("R9 pulse 0x61", {22'd0, region_chg}, 32'h00E);
    check("R7 attr 0x61", {12'd0, seg_attr}, 32'h000E4);
    @(negedge clk);
    check("R9 pulse one cycle", {22'd0, region_chg}, 32'h0);
    write(3'd0, 8'h61, 8'hE4);
    check("R9 same value no pulse", {22'd0, region_chg}, 32'h0);
    write(3'd0, 8'h62, 8'h30);
    check("R9 pulse 0x62", {22'd0, region_chg}, 32'h040);
    check("R7 attr 0x62", {12'd0, seg_attr}, 32'h030E4);
    write(3'd0, 8'h63, 8'h20);
    check("R9 pulse top", {22'd0, region_chg}, 32'h200);
    check("R7 attr 0x63", {12'd0, seg_attr}, 32'h830E4);
    check("R8 bios set", {31'd0, bios_shadow}, 32'd1);
    write(3'd0, 8'h63, 8'hD0);
    check("R9 pulse both 64K", {22'd0, region_chg}, 32'h300);
    check("R7 attr 0x63 b", {12'd0, seg_attr}, 32'h730E4);
    check("R8 bios clear", {31'd0, bios_shadow}, 32'd0);
    write(3'd2, 8'h61, 8'h00);
    check("R10 foreign write pulse", {22'd0, region_chg}, 32'h0);
    check("R10 foreign write attr", {12'd0, seg_attr}, 32'h730E4);

    // R11: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    read(8'h80, rd);
    check("R11 byte 0x80", {24'd0, rd}, 32'h00);
    read(8'h04, rd);
    check("R11 byte 0x04", {24'd0, rd}, 32'h07);
    check("R11 attr", {12'd0, seg_attr}, 32'h0);
    check("R11 bios", {31'd0, bios_shadow}, 32'd0);
    check("R11 pulse", {22'd0, region_chg}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule